// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This block clears one whole cache block of memory in response to a single request. The requester presents a byte address. The engine rounds the address down to the start of the block that contains it. It asks a permission checker whether storing to that entire block is allowed, and only after a grant does it overwrite the block with zeros. The writes go out through a word-wide memory write port, one word per cycle in rising address order. A denied request ends at once with a store-fault indication, and memory is left untouched.

The block length and the write-port width are parameters. The block length defaults to 64 bytes. It must be a power of two and a whole multiple of the word width.

The control is a five-state machine:
- **IDLE**: waits for a request. A request with `req_valid` high is accepted here (IDLE→CHECK), and the aligned base address is captured at that point.
- **CHECK**: holds the permission request until a response arrives. A grant leads to WRITE (CHECK→WRITE) and a denial leads to FAULT (CHECK→FAULT).
- **WRITE**: issues one zero word per cycle. After the last word it moves on (WRITE→DONE).
- **DONE**: signals completion for one cycle and returns to IDLE.
- **FAULT**: signals completion and a store fault together for one cycle and returns to IDLE.

Top module: `blkz_engine`

## Requirements
- R1: The permission request address and the first write address equal the request address with its low log2(BLOCK_BYTES) bits cleared.
- R2: `perm_req` stays high from the cycle after acceptance until a cycle with `perm_rsp_valid` high, and `perm_size` equals BLOCK_BYTES while it is high.
- R3: No memory write is issued before the permission response has granted access, and the first write follows the grant in the next cycle.
- R4: Every word written carries `wr_data` of zero and `wr_be` with all bits set.
- R5: A granted request produces exactly BLOCK_BYTES/WORD_BYTES writes on consecutive cycles, each address WORD_BYTES above the previous one.
- R6: `done` is high for exactly one cycle, the cycle after the last write, with `fault` low.
- R7: A denied permission response (`perm_rsp_valid` high, `perm_rsp_ok` low) makes `done` and `fault` high together for one cycle in the next cycle, and no write is issued.
- R8: A request is accepted only while `req_ready` is high, which is the case only in IDLE. A `req_valid` presented while busy has no effect: it starts no permission request afterwards and changes no memory.
- R9: After reset, `req_ready` is high and `perm_req`, `wr_en`, `done` and `fault` are low.
- R10: Bytes outside the aligned block are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Zeroing request present |
| req_addr | input | ADDR_W | Any byte address inside the block to clear |
| req_ready | output | 1 | Engine idle; a request is accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Store fault; high together with `done` on denial |
| perm_req | output | 1 | Store permission request, held until answered |
| perm_addr | output | ADDR_W | Aligned block base to check |
| perm_size | output | $clog2(BLOCK_BYTES)+1 | Access size in bytes (BLOCK_BYTES) |
| perm_rsp_valid | input | 1 | Permission response present |
| perm_rsp_ok | input | 1 | 1 = store allowed, 0 = denied |
| wr_en | output | 1 | Memory word write strobe |
| wr_addr | output | ADDR_W | Byte address of the word written |
| wr_data | output | 8*WORD_BYTES | Write data (always zero) |
| wr_be | output | WORD_BYTES | Byte enables |

## Verification
A wrong state in the controller shows up at the write port within one cycle. If the engine writes while it is still checking, the write appears before the grant. If the word counter is off, the run has the wrong number of writes or an address gap, and `done` arrives early or late relative to the last write. If the base register is wrong, zeros land outside the aligned block; this is found when the whole shadow memory is compared after each operation. A machine that fails to leave a busy state shows `req_ready` low, with no `done`, within a few cycles of the expected end.

// File: rtl/blkz_pkg.sv
package blkz_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_WRITE = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } blkz_state_t;
endpackage

// File: rtl/blkz_align.sv
module blkz_align #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_out
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(BLOCK_BYTES - 1);

    always_comb begin
        base_out = addr_in & ~OFS_MASK;
    end
endmodule

// File: rtl/blkz_word_ctr.sv
module blkz_word_ctr #(
    parameter int WORDS = 16,
    localparam int CW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        last = (cnt == LAST_IDX);
    end
endmodule

// File: rtl/blkz_fsm.sv
module blkz_fsm
    import blkz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rsp_valid,
    input  logic rsp_ok,
    input  logic last_word,
    output logic ready,
    output logic accept,
    output logic perm_req,
    output logic wr_en,
    output logic done,
    output logic fault
);
    blkz_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: if (rsp_valid) state_d = rsp_ok ? ST_WRITE : ST_FAULT;
            ST_WRITE: if (last_word) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        perm_req = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        fault    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_CHECK: perm_req = 1'b1;
            ST_WRITE: wr_en = 1'b1;
            ST_DONE:  done = 1'b1;
            ST_FAULT: begin
                done  = 1'b1;
                fault = 1'b1;
            end
            default: ;
        endcase
        accept = ready & start;
    end

    // R2
    perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_req && !rsp_valid |=> perm_req);

    // R3
    write_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !$past(wr_en) |-> $past(rsp_valid && rsp_ok));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done && $past(rsp_valid && !rsp_ok));

    // R8
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_req && !$past(perm_req) |-> $past(start && ready));
endmodule

// File: rtl/blkz_engine.sv
module blkz_engine #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int WORD_BYTES  = 4,
    localparam int DATA_W     = 8 * WORD_BYTES,
    localparam int SIZE_W     = $clog2(BLOCK_BYTES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  req_ready,
    output logic                  done,
    output logic                  fault,
    output logic                  perm_req,
    output logic [ADDR_W-1:0]     perm_addr,
    output logic [SIZE_W-1:0]     perm_size,
    input  logic                  perm_rsp_valid,
    input  logic                  perm_rsp_ok,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [WORD_BYTES-1:0] wr_be
);
    localparam int WORDS   = BLOCK_BYTES / WORD_BYTES;
    localparam int CW      = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int WB_SH   = $clog2(WORD_BYTES);
    localparam int OFS_W   = $clog2(BLOCK_BYTES);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] base_q;
    logic [CW-1:0]     word_idx;
    logic              last_word;
    logic              accept;

    blkz_align #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
        .addr_in  (req_addr),
        .base_out (aligned)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (accept) begin
            base_q <= aligned;
        end
    end

    blkz_word_ctr #(.WORDS(WORDS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (wr_en),
        .cnt   (word_idx),
        .last  (last_word)
    );

    blkz_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .rsp_valid (perm_rsp_valid),
        .rsp_ok    (perm_rsp_ok),
        .last_word (last_word),
        .ready     (req_ready),
        .accept    (accept),
        .perm_req  (perm_req),
        .wr_en     (wr_en),
        .done      (done),
        .fault     (fault)
    );

    always_comb begin
        perm_addr = base_q;
        perm_size = SIZE_W'(BLOCK_BYTES);
        wr_addr   = base_q + (ADDR_W'(word_idx) << WB_SH);
        wr_data   = '0;
        wr_be     = wr_en ? '1 : '0;
    end

    // R1
    perm_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_req |-> perm_addr[OFS_W-1:0] == '0);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ADDR_W'(WORD_BYTES));

    // R10
    write_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr & ~ADDR_W'(BLOCK_BYTES - 1)) == perm_addr);
endmodule

// File: tb/blkz_engine_test.sv
module blkz_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int BLOCK_BYTES = 64;
    localparam int WORD_BYTES = 4;
    localparam int WORDS = BLOCK_BYTES / WORD_BYTES;
    localparam int MEM_WORDS = 128;
    localparam int SIZE_W = $clog2(BLOCK_BYTES) + 1;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, done, fault, perm_req, wr_en;
    logic [ADDR_W-1:0] perm_addr, wr_addr;
    logic [SIZE_W-1:0] perm_size;
    logic perm_rsp_valid = 0;
    logic perm_rsp_ok = 0;
    logic [31:0] wr_data;
    logic [3:0] wr_be;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] exp_mem [MEM_WORDS];

    int wr_count;
    int first_wr_addr;
    int last_wr_cyc;
    int prev_wr_addr;
    bit order_bad;
    bit data_bad;
    bit range_bad;

    blkz_engine #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .done(done), .fault(fault), .perm_req(perm_req),
        .perm_addr(perm_addr), .perm_size(perm_size), .perm_rsp_valid(perm_rsp_valid),
        .perm_rsp_ok(perm_rsp_ok), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // write monitor: applies writes to the bench memory
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (wr_count > 0 && (int'(wr_addr) != prev_wr_addr + WORD_BYTES || cyc != last_wr_cyc + 1))
                order_bad = 1;
            if (wr_count == 0) first_wr_addr = int'(wr_addr);
            if (wr_data != 0 || wr_be != 4'hF) data_bad = 1;
            if (wr_addr / 4 < MEM_WORDS) mem[wr_addr / 4] = 32'h0;
            else range_bad = 1;
            prev_wr_addr = int'(wr_addr);
            last_wr_cyc = cyc;
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic mon_clear();
        wr_count = 0; order_bad = 0; data_bad = 0; range_bad = 0;
        first_wr_addr = -1; last_wr_cyc = -10; prev_wr_addr = 0;
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int bad_idx = 0;
        for (int i = 0; i < MEM_WORDS; i++)
            if (mem[i] !== exp_mem[i]) begin bad++; bad_idx = i; end
        chk(bad == 0, req, mem[bad_idx], exp_mem[bad_idx]);
    endtask

    // Issue one request, answer the permission request after lat cycles.
    task automatic run_op(input int addr, input int lat, input bit grant,
                          output int done_cyc, output bit done_fault);
        int base = addr & ~(BLOCK_BYTES - 1);
        bit early_wr = 0;
        bit drop = 0;
        int n;
        mon_clear();
        @(negedge clk);
        chk(req_ready == 1, "R8 ready in idle", req_ready, 1);
        req_valid = 1; req_addr = addr;
        @(negedge clk);
        req_valid = 0;
        chk(perm_req == 1 && perm_addr == base, "R1 perm addr", perm_addr, base);
        chk(perm_size == BLOCK_BYTES, "R2 perm size", perm_size, BLOCK_BYTES);
        for (int k = 0; k < lat; k++) begin
            if (wr_en) early_wr = 1;
            @(negedge clk);
            if (!perm_req) drop = 1;
        end
        chk(!drop, "R2 perm_req held", drop, 0);
        chk(!early_wr && wr_count == 0, "R3 no write before grant", wr_count, 0);
        perm_rsp_valid = 1; perm_rsp_ok = grant;
        @(negedge clk);
        perm_rsp_valid = 0; perm_rsp_ok = 0;
        if (grant) chk(wr_en == 1, "R3 write follows grant", wr_en, 1);
        n = 0;
        while (!done && n < WORDS + 8) begin @(negedge clk); n++; end
        done_cyc = cyc;
        done_fault = fault;
        @(negedge clk);
        chk(done == 0, "R6 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1, "R9 ready after reset", req_ready, 1);
        chk(!perm_req && !wr_en && !done && !fault, "R9 outputs idle",
            {perm_req, wr_en, done, fault}, 0);
    endtask

    task automatic t_zero(input int addr, input int lat);
        int base = addr & ~(BLOCK_BYTES - 1);
        int dc;
        bit df;
        for (int i = 0; i < WORDS; i++) exp_mem[base / 4 + i] = 32'h0;
        run_op(addr, lat, 1, dc, df);
        chk(first_wr_addr == base, "R1 first write addr", first_wr_addr, base);
        chk(wr_count == WORDS, "R5 write count", wr_count, WORDS);
        chk(!order_bad, "R5 ascending consecutive", order_bad, 0);
        chk(!data_bad, "R4 zero data full enables", data_bad, 0);
        chk(dc == last_wr_cyc + 1 && !df, "R6 done after last write", dc, last_wr_cyc + 1);
        chk(!range_bad, "R10 write range", range_bad, 0);
        cmp_mem("R4 R10 memory image");
    endtask

    task automatic t_deny(input int addr);
        int dc;
        bit df;
        run_op(addr, 2, 0, dc, df);
        chk(df == 1, "R7 fault with done", df, 1);
        chk(wr_count == 0, "R7 no writes", wr_count, 0);
        cmp_mem("R7 memory unchanged");
    endtask

    task automatic t_busy(input int addr_a, input int addr_b);
        int base = addr_a & ~(BLOCK_BYTES - 1);
        bit rdy_seen = 0;
        bit extra = 0;
        int n;
        for (int i = 0; i < WORDS; i++) exp_mem[base / 4 + i] = 32'h0;
        mon_clear();
        @(negedge clk);
        req_valid = 1; req_addr = addr_a;
        @(negedge clk);
        req_addr = addr_b;
        @(negedge clk);
        perm_rsp_valid = 1; perm_rsp_ok = 1;
        @(negedge clk);
        perm_rsp_valid = 0; perm_rsp_ok = 0;
        n = 0;
        while (!done && n < WORDS + 8) begin
            if (req_ready) rdy_seen = 1;
            @(negedge clk); n++;
        end
        req_valid = 0;
        chk(!rdy_seen, "R8 not ready while busy", rdy_seen, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (perm_req || wr_en) extra = 1;
        end
        chk(!extra, "R8 busy request ignored", extra, 0);
        chk(first_wr_addr == base, "R8 first address kept", first_wr_addr, base);
        cmp_mem("R8 other block untouched");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i] = 32'hA500_0000 | i;
            exp_mem[i] = 32'hA500_0000 | i;
        end
        mon_clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_zero(32'h47, 0);
        t_zero(32'h80, 3);
        t_zero(32'h1FF, 1);
        t_deny(32'h13C);
        t_busy(32'h104, 32'h18C);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule